// File: doc/BRIEF.md
# Even-Ratio Modular Programmable Divider

This block divides a fast input clock by an even integer chosen from 24 to 38. It sits in the feedback path of an integer-N frequency synthesizer, where its output goes to the phase-frequency detector. A fixed divide-by-2 stage comes first. Three dual-modulus cells follow it: two that divide by 2 or 3 and a last cell that divides by 3 or 4. A 3-bit ratio word picks the total division.

Each cell advances once for every output cycle of the stage before it. All registers are clocked by the input clock, and a one-cycle strobe passes down the chain. Each cell divides by its base modulus, except in one output cycle per overall period. In that cycle the later cells assert the modulus control, and the cell stretches the cycle by one input period if its ratio bit is set. The control is formed first at the last cell and passed back toward the first, so no pulse-swallow counter and no phase-select state machine is needed. The ratio word is sampled only at the start of each output period. The output is a registered clock, high for a fixed part of each period.

Top module: `evdiv_top`

## Requirements
- R1: With code = ratio[2:0] read as an unsigned number, the output period is 24 + 2*code input clocks. Bit 0 adds 2 clocks, bit 1 adds 4 and bit 2 adds 8.
- R2: The leading divide-by-2 stage toggles on every input clock out of reset, so every output period is an even number of input clocks.
- R3: Each cell divides by its base modulus (2, 2 and then 3, counting from the input). It stretches exactly one of its output cycles per overall period by one input cycle, and only when its ratio bit is set. The period repeats identically from one output cycle to the next.
- R4: Codes 0 to 5 give the operating ratios 24, 26, 28, 30, 32 and 34. Codes 6 and 7 give the reserved ratios 36 and 38.
- R5: In each period the output is high for 12 input clocks when ratio[2]=0 and for 16 when ratio[2]=1. It is low for the rest of the period.
- R6: A change of the ratio word takes effect only at the next rising edge of the output. The period in progress finishes with the old ratio, and the period after that edge uses the new one.
- R7: While rst is high, div_out is low and the ratio word is sampled. The first rising edge of div_out comes exactly N input clocks after the first clock edge at which rst is low, where N is the programmed ratio.
- R8: Asserting rst in the middle of operation forces div_out low. Releasing it restarts the division from the R7 starting point with the newly sampled ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | 3 | Ratio word; total division is 24 + 2*ratio |
| div_out | output | 1 | Registered divided clock for the phase detector |

## Verification
A cell whose count is corrupted, or whose modulus control is taken from the wrong stage, shows up within one output period. It appears as a rising edge of div_out that is early or late against the expected period in input clocks. A wrong extension bit changes the period by exactly 2, 4 or 8 clocks, so each ratio bit is tied to one cell. A wrong prescaler phase or reset state moves the first edge after reset. A ratio register that loads at the wrong moment produces one period of mixed length right after the ratio word changes.

// File: rtl/evdiv_pkg.sv
package evdiv_pkg;
  // Number of dual-modulus cells after the fixed /2 stage.
  localparam int CELLS = 3;

  // Base modulus of a cell: the last one is a 3/4 cell, the rest are 2/3.
  function automatic int cell_base(input int idx, input int cells);
    return (idx == cells - 1) ? 3 : 2;
  endfunction

  // Counter width large enough for the stretched count of the widest cell.
  localparam int CW = $clog2(cell_base(CELLS - 1, CELLS) + 1);
endpackage

// File: rtl/evdiv_prescale.sv
module evdiv_prescale (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= 1'b0;
    else     pre_q <= ~pre_q;
  end

  // One strobe every second input clock.
  assign tick_o = pre_q;

  assert_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pre_q != $past(pre_q)));
endmodule

// File: rtl/evdiv_cell.sv
module evdiv_cell #(
  parameter int BASE = 2,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_in,
  input  logic          ext_en,
  output logic [CW-1:0] cnt_o,
  output logic          at_base_end,
  output logic          at_ext_end
);
  localparam logic [CW-1:0] BASE_LAST = CW'(BASE - 1);
  localparam logic [CW-1:0] EXT_LAST  = CW'(BASE);

  logic [CW-1:0] cnt_q;
  logic          term;

  assign term = ext_en ? (cnt_q == EXT_LAST) : (cnt_q == BASE_LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_in) cnt_q <= term ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign at_base_end = (cnt_q == BASE_LAST);
  assign at_ext_end  = (cnt_q == EXT_LAST);

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= EXT_LAST);
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_in && term) |=> (cnt_q == '0));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> $stable(cnt_q));
endmodule

// File: rtl/evdiv_top.sv
module evdiv_top #(
  parameter int CELLS = evdiv_pkg::CELLS,
  parameter int CW    = evdiv_pkg::CW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CELLS-1:0] ratio,
  output logic             div_out
);
  localparam int LAST      = CELLS - 1;
  localparam int LAST_BASE = evdiv_pkg::cell_base(LAST, CELLS);

  logic             pre_tick;
  logic [CELLS-1:0] p_q;
  logic [CELLS-1:0] ext_v, term_v, tin_v;
  logic [CELLS-1:0] at_base, at_ext;
  logic [CW-1:0]    cnt_a [CELLS];
  logic             wrap, fall, out_q;

  evdiv_prescale u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_o (pre_tick)
  );

  generate
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
      evdiv_cell #(
        .BASE (evdiv_pkg::cell_base(i, CELLS)),
        .CW   (CW)
      ) u_cell (
        .clk         (clk),
        .rst         (rst),
        .tick_in     (tin_v[i]),
        .ext_en      (ext_v[i]),
        .cnt_o       (cnt_a[i]),
        .at_base_end (at_base[i]),
        .at_ext_end  (at_ext[i])
      );
    end
  endgenerate

  // Modulus control runs from the last cell back to the first; the strobe
  // runs forward from the prescaler.
  always_comb begin
    logic m;
    logic t;
    m = 1'b1;
    for (int i = CELLS - 1; i >= 0; i--) begin
      ext_v[i]  = p_q[i] & m;
      term_v[i] = ext_v[i] ? at_ext[i] : at_base[i];
      m         = m & term_v[i];
    end
    t = pre_tick;
    for (int i = 0; i < CELLS; i++) begin
      tin_v[i] = t;
      t        = t & term_v[i];
    end
    wrap = t;
  end

  // Falling edge near mid-period: on a last-cell input boundary when its
  // length is even, else half way through the next earlier cell's cycle.
  always_comb begin
    int lval;
    lval = LAST_BASE + int'(p_q[LAST]);
    if ((lval % 2) == 0)
      fall = tin_v[LAST] && (cnt_a[LAST] == CW'(lval / 2 - 1));
    else
      fall = tin_v[LAST-1] && (cnt_a[LAST-1] == '0) &&
             (cnt_a[LAST] == CW'((lval - 1) / 2));
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) p_q <= ratio;
  end

  always_ff @(posedge clk) begin
    if (rst)       out_q <= 1'b0;
    else if (wrap) out_q <= 1'b1;
    else if (fall) out_q <= 1'b0;
  end

  assign div_out = out_q;

  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(p_q));
  assert_rise_on_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> out_q);
  assert_low_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!out_q && !wrap) |=> !out_q);
  assert_no_clash_R5: assert property (@(posedge clk) disable iff (rst)
    !(wrap && fall));
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (tin_v[0] == 1'b0) |-> (tin_v == '0));
endmodule

// File: tb/tb_evdiv_top.sv
module tb_evdiv_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio = 3'd0;
  logic       div_out;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evdiv_top dut (.clk(clk), .rst(rst), .ratio(ratio), .div_out(div_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(input logic lvl, output int at);
    logic prev;
    int   lim;
    prev = div_out;
    lim  = 0;
    at   = -1;
    forever begin
      @(negedge clk);
      if (prev != lvl && div_out == lvl) begin
        at = cyc;
        return;
      end
      prev = div_out;
      lim++;
      if (lim > 400) begin
        check(1'b0, "watchdog edge wait", lim, 400);
        return;
      end
    end
  endtask

  // Resets with the given code; returns the cycle count at release.
  task automatic do_reset(input int code, output int rel);
    @(negedge clk);
    rst   = 1'b1;
    ratio = 3'(code);
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R7 low in reset", int'(div_out), 0);
    rst = 1'b0;
    rel = cyc;
  endtask

  task automatic t_period(input int code);
    int rel, a, f, b, c, n, hi;
    n  = 24 + 2 * code;
    hi = (code >= 4) ? 16 : 12;
    do_reset(code, rel);
    wait_edge(1'b1, a);
    check(a - rel == n, "R7 first edge latency", a - rel, n);
    wait_edge(1'b0, f);
    check(f - a == hi, "R5 high time", f - a, hi);
    wait_edge(1'b1, b);
    if (code >= 6) check(b - a == n, "R4 reserved ratio period", b - a, n);
    else           check(b - a == n, "R1 R4 operating period", b - a, n);
    wait_edge(1'b1, c);
    check(c - b == n && ((c - b) % 2) == 0, "R2 R3 repeated even period", c - b, n);
  endtask

  task automatic t_ratio_change(input int ca, input int cb, input int delay);
    int rel, r0, r1, r2;
    do_reset(ca, rel);
    wait_edge(1'b1, r0);
    repeat (delay) @(negedge clk);
    ratio = 3'(cb);
    wait_edge(1'b1, r1);
    check(r1 - r0 == 24 + 2 * ca, "R6 old ratio finishes", r1 - r0, 24 + 2 * ca);
    wait_edge(1'b1, r2);
    check(r2 - r1 == 24 + 2 * cb, "R6 new ratio applies", r2 - r1, 24 + 2 * cb);
  endtask

  task automatic t_reset_mid();
    int rel, a, r;
    do_reset(5, rel);
    wait_edge(1'b1, a);
    repeat (7) @(negedge clk);
    rst   = 1'b1;
    ratio = 3'd2;
    @(negedge clk);
    check(div_out == 1'b0, "R8 forced low", int'(div_out), 0);
    @(negedge clk);
    rst = 1'b0;
    rel = cyc;
    wait_edge(1'b1, r);
    check(r - rel == 28, "R8 restart latency", r - rel, 28);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog global", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int code = 0; code < 8; code++) t_period(code);
    t_ratio_change(0, 7, 5);
    t_ratio_change(6, 1, 30);
    t_ratio_change(3, 4, 2);
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule